// File: doc/BRIEF.md
# Multi-Mode Interval Counter

This block is one 16-bit down-counting channel with a one-cycle count-enable input (`tick`), a gate input and a single waveform output. A host loads a mode byte and a two-byte count value, and it can read the live count back one byte at a time. Six modes cover these behaviours: an output that rises once at terminal count, a one-shot started by the gate, a rate generator, a square-wave divider, a software-started strobe and a gate-started strobe.

All state changes on the rising edge of one system clock. Each counter clock event reaches the block as a one-cycle `tick`. A tick that arrives in the same cycle as a host write is dropped. In this document, "N" is the loaded count, and a loaded count of 0 counts as 65536. "The load tick" is the tick on which N enters the counter. "k" is the number of counting ticks that have been applied since the load tick.

Top module: `interval_counter`

## Requirements
- R1: After reset, `wave` is 1, the mode is 0, and reading the count returns 0x00 and then 0x00.
- R2: A write with `wr_ctl`=1 takes the mode from `wr_data[2:0]`. Codes 6 and 7 act as modes 2 and 3. Such a write discards a half-written count, so the next count byte is taken as the low byte. One cycle later, `wave` is 0 in mode 0 and 1 in every other mode.
- R3: A count is written as two bytes with `wr_ctl`=0, low byte first. The cycle after the high byte is written, `wave` is 0 in mode 0 and 1 otherwise. In modes 0, 2, 3 and 4 the value is loaded on the next tick. In modes 1 and 5 it is loaded on a trigger. A value of 0 behaves as 65536, so the tick after loading 0 leaves 0xFFFF.
- R4: In mode 0, `wave` stays 0 after the load tick. It rises on the N-th counting tick and then stays 1 until the next count or mode write.
- R5: In modes 0, 2, 3 and 4, a tick that arrives while `gate` is 0 changes neither the count nor `wave`.
- R6: In mode 1, a rising `gate` edge after the count is written arms a trigger. The next tick loads N and drives `wave` to 0, and `wave` returns to 1 on the N-th tick after that. The gate level does not pause counting, and a new rising edge restarts the count from N.
- R7: In mode 2 the count runs N, N-1, ..., 1 and then reloads N with no host action. `wave` is 0 only during the one tick period in which the count is 1.
- R8: In mode 3 the count follows the same reload cycle as mode 2. `wave` is 1 while the count is above floor(N/2) and 0 otherwise, so an odd N gives the extra tick to the high half.
- R9: In mode 4, `wave` is 0 for exactly one tick period, starting at the N-th tick after the load tick when the count reaches 0. This happens once per load.
- R10: Mode 5 behaves like mode 4 except that loading waits for a rising `gate` edge. Without an edge, ticks change nothing.
- R11: A read pulse `rd_en` moves the byte pointer. `rd_data` shows the low byte first, then the high byte, and then the low byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_ctl | input | 1 | 1 = mode byte, 0 = count byte |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Read pulse; advances the byte pointer |
| rd_data | output | 8 | Selected byte of the live count |
| tick | input | 1 | One-cycle counter clock event |
| gate | input | 1 | Gate level / trigger input |
| wave | output | 1 | Counter output waveform |

## Verification
Random counts between 2 and 15 exercise modes 2, 3 and 4, with `wave` checked after every tick. This separates the reload-at-1 timing from the pulse-at-0 timing, and shows whether the square wave splits an odd N with the longer half high. Directed cases hold `gate` low in the middle of a count, which tells a suspended mode apart from a one-shot that keeps counting. They also raise `gate` a second time to show that mode 1 restarts on a new edge, and hold `gate` steady in mode 5 to show that nothing starts without an edge. Further directed cases load zero, write a mode byte in the middle of a count write, and use the alias mode codes, which together check the 65536 rule and the resetting of the byte pointer.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   typedef enum logic [2:0] {
      M_TERM     = 3'd0,
      M_ONESHOT  = 3'd1,
      M_RATE     = 3'd2,
      M_SQUARE   = 3'd3,
      M_SWSTROBE = 3'd4,
      M_HWSTROBE = 3'd5
   } ivc_mode_e;

   // codes 6 and 7 alias onto rate and square
   function automatic ivc_mode_e decode_mode(input logic [2:0] raw);
      ivc_mode_e m;
      case (raw)
         3'd0:    m = M_TERM;
         3'd1:    m = M_ONESHOT;
         3'd2:    m = M_RATE;
         3'd3:    m = M_SQUARE;
         3'd4:    m = M_SWSTROBE;
         3'd5:    m = M_HWSTROBE;
         3'd6:    m = M_RATE;
         default: m = M_SQUARE;
      endcase
      return m;
   endfunction

   function automatic logic gate_started(input ivc_mode_e m);
      return (m == M_ONESHOT) || (m == M_HWSTROBE);
   endfunction

endpackage

// File: rtl/ivc_host_port.sv
module ivc_host_port
   import ivc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ctl,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  cnt,
   output ivc_mode_e         mode,
   output ivc_mode_e         mode_nxt,
   output logic              mode_wr,
   output logic              load_req,
   output logic [CNT_W-1:0]  init_val,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int NBYTES = CNT_W / BYTE_W;

   initial begin
      assert (NBYTES == 2 && CNT_W % BYTE_W == 0)
         else $error("ivc_host_port: count must be exactly two bytes");
      assert (BYTE_W >= 3)
         else $error("ivc_host_port: byte too narrow for mode field");
   end

   ivc_mode_e         mode_q;
   logic [BYTE_W-1:0] lo_q;
   logic              wr_hi_q;
   logic              rd_hi_q;
   logic [CNT_W-1:0]  init_q;

   assign mode_wr  = wr_en && wr_ctl;
   assign load_req = wr_en && !wr_ctl && wr_hi_q;
   assign mode_nxt = mode_wr ? decode_mode(wr_data[2:0]) : mode_q;
   assign mode     = mode_q;
   assign init_val = init_q;
   assign rd_data  = rd_hi_q ? cnt[CNT_W-1 -: BYTE_W] : cnt[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= M_TERM;
         lo_q    <= '0;
         wr_hi_q <= 1'b0;
         rd_hi_q <= 1'b0;
         init_q  <= '0;
      end else if (mode_wr) begin
         mode_q  <= mode_nxt;
         wr_hi_q <= 1'b0;
         rd_hi_q <= 1'b0;
      end else begin
         if (wr_en) begin
            if (!wr_hi_q) begin
               lo_q    <= wr_data;
               wr_hi_q <= 1'b1;
            end else begin
               init_q  <= {wr_data, lo_q};
               wr_hi_q <= 1'b0;
            end
         end
         if (rd_en) rd_hi_q <= !rd_hi_q;
      end
   end

   assert_read_alternates_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mode_wr) |=> (rd_hi_q != $past(rd_hi_q)));

   assert_mode_ptr_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (!wr_hi_q && !rd_hi_q));

endmodule

// File: rtl/ivc_gate_sense.sv
module ivc_gate_sense #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   input  logic clr,
   input  logic take,
   output logic gate_lvl,
   output logic trig
);

   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("ivc_gate_sense: SYNC_STAGES out of range");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign gate_lvl = gate;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], gate} & {SYNC_STAGES{1'b1}};
         end
         assign gate_lvl = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic gate_q;
   logic trig_q;
   logic rise;

   assign rise = gate_lvl && !gate_q;
   assign trig = trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_q <= 1'b0;
         trig_q <= 1'b0;
      end else begin
         gate_q <= gate_lvl;
         if (clr)       trig_q <= 1'b0;
         else if (rise) trig_q <= 1'b1;
         else if (take) trig_q <= 1'b0;
      end
   end

   assert_trig_from_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_q) |-> $past(rise));

endmodule

// File: rtl/ivc_core.sv
module ivc_core
   import ivc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ivc_mode_e        mode,
   input  ivc_mode_e        mode_nxt,
   input  logic             mode_wr,
   input  logic             load_req,
   input  logic [CNT_W-1:0] init_val,
   input  logic             tick,
   input  logic             gate_lvl,
   input  logic             trig,
   output logic             trig_take,
   output logic [CNT_W-1:0] cnt,
   output logic             wave
);

   localparam int EFF_W = CNT_W + 1;
   localparam logic [EFF_W-1:0] FULL = EFF_W'(1) << CNT_W;

   logic [CNT_W-1:0] cnt_q;
   logic             out_q, run_q, armed_q, pend_q, valid_q;

   logic             by_gate, host_busy, start, step, reload_at_one, hit0;
   logic [CNT_W-1:0] cnt_nxt;
   logic             out_calc, armed_calc;
   logic [EFF_W-1:0] eff_nxt, eff_half;

   function automatic logic [EFF_W-1:0] eff(input logic [CNT_W-1:0] v);
      return (v == '0) ? FULL : {1'b0, v};
   endfunction

   assign by_gate   = gate_started(mode);
   assign host_busy = mode_wr || load_req;
   assign start     = tick && !host_busy && (by_gate ? (valid_q && trig) : pend_q);
   assign step      = tick && !host_busy && run_q && !start && (by_gate || gate_lvl);
   assign trig_take = start && by_gate;

   assign reload_at_one = ((mode == M_RATE) || (mode == M_SQUARE)) && (cnt_q == CNT_W'(1));
   assign cnt_nxt = (start || reload_at_one) ? init_val : cnt_q - CNT_W'(1);
   assign hit0    = !start && armed_q && (cnt_nxt == '0);
   assign eff_nxt  = eff(cnt_nxt);
   assign eff_half = eff(init_val) >> 1;

   always_comb begin
      out_calc   = out_q;
      armed_calc = start ? 1'b1 : armed_q;
      case (mode)
         M_TERM: begin
            if (hit0) begin
               out_calc   = 1'b1;
               armed_calc = 1'b0;
            end
         end
         M_ONESHOT: begin
            if (start) out_calc = 1'b0;
            else if (hit0) begin
               out_calc   = 1'b1;
               armed_calc = 1'b0;
            end
         end
         M_RATE:   out_calc = (cnt_nxt != CNT_W'(1));
         M_SQUARE: out_calc = (eff_nxt > eff_half);
         default: begin
            out_calc = !hit0;
            if (hit0) armed_calc = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         out_q   <= 1'b1;
         run_q   <= 1'b0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (mode_wr) begin
         run_q   <= 1'b0;
         armed_q <= 1'b0;
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
         out_q   <= (mode_nxt != M_TERM);
      end else if (load_req) begin
         run_q   <= 1'b0;
         armed_q <= 1'b0;
         pend_q  <= !by_gate;
         valid_q <= 1'b1;
         out_q   <= (mode != M_TERM);
      end else if (start || step) begin
         cnt_q   <= cnt_nxt;
         out_q   <= out_calc;
         armed_q <= armed_calc;
         run_q   <= 1'b1;
         if (start) pend_q <= 1'b0;
      end
   end

   assign cnt  = cnt_q;
   assign wave = out_q;

   assert_mode_write_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (out_q == (mode != M_TERM)));

   assert_term_stays_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_TERM && run_q && out_q && !host_busy) |=> out_q);

   assert_gate_low_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !gate_lvl && run_q && !by_gate && !host_busy) |=> ($stable(cnt_q) && $stable(out_q)));

   assert_rate_low_at_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_RATE && run_q && !out_q) |-> (cnt_q == CNT_W'(1)));

   assert_strobe_one_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (((mode == M_SWSTROBE) && gate_lvl || (mode == M_HWSTROBE)) && !out_q && tick && run_q && !host_busy)
      |=> out_q);

endmodule

// File: rtl/interval_counter.sv
module interval_counter
   import ivc_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int GATE_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ctl,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              tick,
   input  logic              gate,
   output logic              wave
);

   ivc_mode_e        mode, mode_nxt;
   logic             mode_wr, load_req, trig, trig_take, gate_lvl;
   logic [CNT_W-1:0] init_val, cnt;

   ivc_host_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_host (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_ctl   (wr_ctl),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .cnt      (cnt),
      .mode     (mode),
      .mode_nxt (mode_nxt),
      .mode_wr  (mode_wr),
      .load_req (load_req),
      .init_val (init_val),
      .rd_data  (rd_data)
   );

   ivc_gate_sense #(.SYNC_STAGES(GATE_SYNC)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (gate),
      .clr      (mode_wr || load_req),
      .take     (trig_take),
      .gate_lvl (gate_lvl),
      .trig     (trig)
   );

   ivc_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .mode_nxt  (mode_nxt),
      .mode_wr   (mode_wr),
      .load_req  (load_req),
      .init_val  (init_val),
      .tick      (tick),
      .gate_lvl  (gate_lvl),
      .trig      (trig),
      .trig_take (trig_take),
      .cnt       (cnt),
      .wave      (wave)
   );

endmodule

// File: tb/interval_counter_test.sv
module interval_counter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_ctl = 1'b0, rd_en = 1'b0, tick = 1'b0, gate = 1'b1;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       wave;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = !clk;

   interval_counter uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .tick(tick), .gate(gate), .wave(wave)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic put(input bit ctl, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_ctl = ctl; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic set_mode(input int m);
      put(1'b1, 8'(m));
   endtask

   task automatic load_val(input int n);
      put(1'b0, 8'(n & 255));
      put(1'b0, 8'((n >> 8) & 255));
   endtask

   task automatic tick1;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic pulse_rd;
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic read_cnt(output int v);
      logic [7:0] lo, hi;
      lo = rd_data;
      pulse_rd();
      hi = rd_data;
      pulse_rd();
      v = {16'd0, hi, lo};
   endtask

   task automatic trig_edge;
      @(negedge clk); gate = 1'b0;
      @(negedge clk); gate = 1'b1;
      @(negedge clk);
   endtask

   function automatic bit exp_wave(input int m, input int n, input int k);
      case (m)
         0, 1:    return k >= n;
         2:       return (k % n) != n - 1;
         3:       return (n - (k % n)) > n / 2;
         default: return k != n;
      endcase
   endfunction

   function automatic int exp_cnt(input int m, input int n, input int k);
      if (m == 2 || m == 3) return n - (k % n);
      return (n - k) & 16'hFFFF;
   endfunction

   function automatic string tag_of(input int m);
      case (m)
         0: return "R4"; 1: return "R6"; 2: return "R7";
         3: return "R8"; 4: return "R9"; default: return "R10";
      endcase
   endfunction

   task automatic run_seq(input int m, input int n, input int kmax);
      int v;
      load_val(n);
      chk(wave == (m != 0), "R3 level after count write", int'(wave), int'(m != 0));
      if (m == 1 || m == 5) trig_edge();
      tick1();
      chk(wave == exp_wave(m, n, 0), tag_of(m), int'(wave), int'(exp_wave(m, n, 0)));
      for (int k = 1; k <= kmax; k++) begin
         tick1();
         chk(wave == exp_wave(m, n, k), tag_of(m), int'(wave), int'(exp_wave(m, n, k)));
      end
      read_cnt(v);
      chk(v == exp_cnt(m, n, kmax), tag_of(m), v, exp_cnt(m, n, kmax));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v, v2, m, n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(wave == 1'b1, "R1 wave", int'(wave), 1);
      read_cnt(v);
      chk(v == 0, "R1 count", v, 0);

      // R2 mode write level
      set_mode(0);
      chk(wave == 1'b0, "R2 mode0 level", int'(wave), 0);
      set_mode(4);
      chk(wave == 1'b1, "R2 mode4 level", int'(wave), 1);

      // R4 mode 0 directed, R3 load on next tick
      set_mode(0);
      run_seq(0, 3, 6);
      load_val(5);
      tick1();
      read_cnt(v);
      chk(v == 5, "R3 value loaded on tick", v, 5);

      // R5 gate low suspends
      tick1(); tick1();
      @(negedge clk); gate = 1'b0;
      tick1(); tick1(); tick1();
      read_cnt(v);
      chk(v == 3, "R5 count held", v, 3);
      chk(wave == 1'b0, "R5 wave held", int'(wave), 0);
      @(negedge clk); gate = 1'b1;
      tick1();
      read_cnt(v);
      chk(v == 2, "R5 resumes", v, 2);

      // R11 read twice gives same, pointer back at low byte
      read_cnt(v2);
      chk(v2 == 2, "R11 repeat read", v2, 2);

      // directed rate and square corner cases
      set_mode(2); run_seq(2, 4, 9);
      set_mode(3); run_seq(3, 5, 11);
      set_mode(3); run_seq(3, 4, 9);
      set_mode(4); run_seq(4, 3, 5);

      // random rate / square / strobe
      for (int i = 0; i < 8; i++) begin
         m = 2 + int'($urandom % 3);
         n = 2 + int'($urandom % 14);
         set_mode(m);
         run_seq(m, n, (m == 4) ? n + 2 : 2 * n + 1);
      end

      // R7 alias code 6 behaves as mode 2
      set_mode(6); run_seq(2, 3, 7);
      // R8 alias code 7 behaves as mode 3
      set_mode(7); run_seq(3, 6, 13);

      // R3 zero means 65536
      set_mode(4);
      load_val(0);
      tick1(); tick1();
      read_cnt(v);
      chk(v == 16'hFFFF, "R3 zero count", v, 16'hFFFF);
      chk(wave == 1'b1, "R3 zero no pulse", int'(wave), 1);

      // R2 mode write cancels half-written count
      set_mode(0);
      put(1'b0, 8'h55);
      set_mode(0);
      load_val(2);
      tick1();
      read_cnt(v);
      chk(v == 2, "R2 pointer reset", v, 2);

      // R6 one-shot, plus gate level ignored and retrigger
      set_mode(1); run_seq(1, 5, 7);
      set_mode(1);
      load_val(4);
      trig_edge();
      tick1(); tick1(); tick1();
      chk(wave == 1'b0, "R6 running low", int'(wave), 0);
      @(negedge clk); gate = 1'b0;
      tick1();
      read_cnt(v);
      chk(v == 1, "R6 gate low keeps counting", v, 1);
      @(negedge clk); gate = 1'b1;
      @(negedge clk);
      tick1();
      read_cnt(v);
      chk(v == 4, "R6 retrigger reload", v, 4);
      chk(wave == 1'b0, "R6 retrigger low", int'(wave), 0);
      tick1(); tick1(); tick1();
      chk(wave == 1'b0, "R6 still low", int'(wave), 0);
      tick1();
      chk(wave == 1'b1, "R6 end high", int'(wave), 1);

      // R10 gate-started strobe: nothing without an edge
      set_mode(5);
      read_cnt(v);
      load_val(4);
      tick1(); tick1(); tick1();
      read_cnt(v2);
      chk(v2 == v, "R10 no edge no load", v2, v);
      chk(wave == 1'b1, "R10 no edge wave", int'(wave), 1);
      set_mode(5); run_seq(5, 4, 6);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule